// File: doc/BRIEF.md
# Two-Dimensional Block Parity Generator and Checker

This block takes in a block of data words one row per beat. It keeps one parity bit for every bit column across all the rows, and it forms one parity bit for every row. The caller chooses odd or even parity, and the block supports two modes.

In generate mode a block is made of `ROWS` data rows. When the last row has been accepted, the block returns the column parity word and the row parity vector. In check mode the caller sends each data row with the row parity bit that was stored for it, and then sends the stored column parity word as one final beat. The block recomputes both sets of parity, compares them with the stored values and reports a column mismatch mask and a row mismatch mask.

Parity runs down the columns as well as along the rows. A burst of neighbouring bits corrupted inside one row therefore still shows up in the column mask, even though that row's parity agrees. When exactly one row and exactly one column disagree, the block reports the row and column indices of the suspect bit. It does not correct that bit.

Top module: `par2d_checker`

## Requirements
- R1: While `rst_n` is low and after its release, `done_o`, `err_loc_o`, `blk_check_o` and every mask, parity and index output are zero until the first block completes.
- R2: In generate mode (`check_mode`=0 at block start) `col_par_o[c]` is chosen so that the XOR of column `c` over all data rows, XOR `col_par_o[c]`, equals the parity select. A parity select of 1 means odd and 0 means even.
- R3: In generate mode `row_par_o[r]` is chosen so that the XOR of the r-th data row (counted from 0 at the start beat), XOR `row_par_o[r]`, equals the parity select.
- R4: `done_o` is high for exactly the one cycle after the beat marked `in_last` is accepted. All result outputs change only in that cycle and hold until the next one.
- R5: In check mode the beat marked `in_last` carries the stored column parity word. `col_err_o[c]` is 1 when column `c` of the data rows, XOR the stored bit, differs from the parity select. `row_err_o[r]` is 1 when row `r`, XOR its `in_rpar`, differs from the parity select. `col_par_o` gives the recomputed column parity.
- R6: Two adjacent data bits flipped in the same row give mismatches on both of their columns and no row mismatch.
- R7: When exactly one bit is set in `row_err_o` and exactly one bit is set in `col_err_o`, `err_loc_o` is 1 and `loc_row_o`/`loc_col_o` hold the indices of those two bits. Otherwise `err_loc_o` and both indices are 0.
- R8: A generate-mode block reports zero mismatch masks and `err_loc_o`=0. A check-mode block reports `row_par_o`=0.
- R9: `odd_sel` and `check_mode` are sampled on the start beat. Changes to them later in the block have no effect on its results.
- R10: Beats with `in_valid` low are ignored. So are beats that arrive while no block is open and do not carry `in_start`.
- R11: A beat carrying `in_start` clears all accumulated column and row state. A block restarted part way through therefore reports only the rows sent from the new start onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat present on the inputs |
| in_start | input | 1 | First beat of a block |
| in_last | input | 1 | Final beat of a block (the stored parity row in check mode) |
| in_data | input | WIDTH | Data row, or the stored column parity word on the check-mode final beat |
| in_rpar | input | 1 | Stored row parity bit for this data row (check mode) |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even; sampled at start |
| check_mode | input | 1 | 1 selects check mode, 0 selects generate mode; sampled at start |
| done_o | output | 1 | One-cycle result strobe |
| blk_check_o | output | 1 | Mode of the block just finished |
| col_par_o | output | WIDTH | Computed column parity word |
| row_par_o | output | ROWS | Computed row parity bits (generate mode) |
| col_err_o | output | WIDTH | Column mismatch mask (check mode) |
| row_err_o | output | ROWS | Row mismatch mask (check mode) |
| err_loc_o | output | 1 | Single bit located |
| loc_row_o | output | RIW | Row index of the located bit |
| loc_col_o | output | CIW | Column index of the located bit |

## Verification
Random generate-mode blocks under both parity senses exercise the column and row sums. Check-mode blocks built from those sums are then sent four ways: untouched, with a single flipped data bit, with two adjacent bits flipped in one row, and with a flipped stored parity bit. Between them these separate the cases of a clean block, a located error, a row-invisible burst, and a column-only mismatch that must not be located. Directed blocks toggle the mode and parity-select inputs part way through a block, insert idle and stray beats, and restart a block part way through. These show that only the start beat's settings and the rows after the last start count.

// File: rtl/par2d_pkg.sv
// par2d_pkg: shared types and helpers for the two-dimensional parity block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package par2d_pkg;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } par_mode_e;

    // Width of an index able to address n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/par2d_row.sv
// par2d_row: combinational parity of one row.
// In generate mode it returns the parity bit that brings the row to the
// selected sense. In check mode it returns 1 when the row and its stored
// parity bit disagree with that sense.
// Assumes: odd_i = 1 means odd parity.
module par2d_row
    import par2d_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             rpar_i,
    input  logic             odd_i,
    input  par_mode_e        mode_i,
    output logic             bit_o
);

    logic row_sum;

    // Fold the row and pick the parity or mismatch result by mode.
    always_comb begin
        row_sum = ^data_i;
        if (mode_i == MODE_CHK) begin
            bit_o = row_sum ^ rpar_i ^ odd_i;
        end else begin
            bit_o = row_sum ^ odd_i;
        end
    end

endmodule

// File: rtl/par2d_colacc.sv
// par2d_colacc: running XOR of the data rows, one bit per column.
// clr_i drops the old sum before this beat. add_i folds in_data into the
// sum. sum_o gives the value the register takes at this edge, so the
// beat being accepted is already included.
// Assumes clr_i and add_i are qualified by a valid beat upstream.
module par2d_colacc #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] sum_o
);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] base;

    // Next sum from the cleared or held base plus the optional row.
    always_comb begin
        base  = clr_i ? '0 : acc_q;
        sum_o = add_i ? (base ^ data_i) : base;
    end

    // Hold the column sums between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i || add_i) begin
            acc_q <= sum_o;
        end
    end

    // R11: a clearing beat with no row leaves an empty sum
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !add_i) |=> (acc_q == '0));

    // R2: a row folded onto a cleared sum equals that row alone
    clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && add_i) |=> (acc_q == $past(data_i)));

endmodule

// File: rtl/par2d_locate.sv
// par2d_locate: finds a single suspect bit from the two mismatch masks.
// hit_o is set only when each mask has exactly one bit set. The indices
// are then those bit positions; otherwise they are zero.
// Assumes the masks are stable for the cycle they are sampled in.
module par2d_locate
    import par2d_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int WIDTH = 5,
    localparam int RIW  = idx_w(ROWS),
    localparam int CIW  = idx_w(WIDTH)
) (
    input  logic [ROWS-1:0]  row_err_i,
    input  logic [WIDTH-1:0] col_err_i,
    output logic             hit_o,
    output logic [RIW-1:0]   row_idx_o,
    output logic [CIW-1:0]   col_idx_o
);

    logic row_one;
    logic col_one;
    logic [RIW-1:0] row_enc;
    logic [CIW-1:0] col_enc;

    // Encode the row mask position (valid only if one-hot).
    always_comb begin
        row_enc = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (row_err_i[i]) row_enc = row_enc | RIW'(i);
        end
    end

    // Encode the column mask position (valid only if one-hot).
    always_comb begin
        col_enc = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (col_err_i[i]) col_enc = col_enc | CIW'(i);
        end
    end

    // Declare a hit only for one row and one column, else zero indices.
    always_comb begin
        row_one   = (row_err_i != '0) && ((row_err_i & (row_err_i - 1'b1)) == '0);
        col_one   = (col_err_i != '0) && ((col_err_i & (col_err_i - 1'b1)) == '0);
        hit_o     = row_one && col_one;
        row_idx_o = hit_o ? row_enc : '0;
        col_idx_o = hit_o ? col_enc : '0;
    end

    // R7: a hit always names a row that is actually flagged
    hit_row_chk: assert final (!hit_o || row_err_i[row_idx_o]);

endmodule

// File: rtl/par2d_checker.sv
// par2d_checker: two-dimensional block parity generator and checker.
// Rows stream in one per valid beat. in_start opens a block and samples
// odd_sel and check_mode. in_last closes it; in check mode that final
// beat carries the stored column parity word. Results are registered and
// strobed by done_o for one cycle.
// Assumes at most ROWS data rows per block; extra data rows add to the
// column sums but get no row bit.
module par2d_checker
    import par2d_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int WIDTH = 5,
    localparam int RIW  = idx_w(ROWS),
    localparam int CIW  = idx_w(WIDTH),
    localparam int CNTW = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_last,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_rpar,
    input  logic             odd_sel,
    input  logic             check_mode,
    output logic             done_o,
    output logic             blk_check_o,
    output logic [WIDTH-1:0] col_par_o,
    output logic [ROWS-1:0]  row_par_o,
    output logic [WIDTH-1:0] col_err_o,
    output logic [ROWS-1:0]  row_err_o,
    output logic             err_loc_o,
    output logic [RIW-1:0]   loc_row_o,
    output logic [CIW-1:0]   loc_col_o
);

    // Block context
    logic             open_q;
    par_mode_e        mode_q;
    logic             odd_q;
    logic [CNTW-1:0]  ridx_q;
    logic [ROWS-1:0]  rows_q;

    // Effective per-beat values
    logic             beat;
    par_mode_e        mode_e;
    logic             odd_e;
    logic [CNTW-1:0]  ridx_e;
    logic             par_beat;
    logic             row_beat;
    logic             row_bit;
    logic [ROWS-1:0]  rows_next;
    logic [WIDTH-1:0] col_sum;
    logic [WIDTH-1:0] col_par_n;
    logic [WIDTH-1:0] col_err_n;
    logic [ROWS-1:0]  row_err_n;
    logic             hit;
    logic [RIW-1:0]   hit_row;
    logic [CIW-1:0]   hit_col;

    // Qualify the beat and resolve the mode, sense and row index in force.
    always_comb begin
        beat     = in_valid && (in_start || open_q);
        mode_e   = in_start ? par_mode_e'(check_mode) : mode_q;
        odd_e    = in_start ? odd_sel : odd_q;
        ridx_e   = in_start ? '0 : ridx_q;
        par_beat = beat && in_last && (mode_e == MODE_CHK);
        row_beat = beat && !par_beat;
    end

    par2d_row #(.WIDTH(WIDTH)) u_row (
        .data_i (in_data),
        .rpar_i (in_rpar),
        .odd_i  (odd_e),
        .mode_i (mode_e),
        .bit_o  (row_bit)
    );

    par2d_colacc #(.WIDTH(WIDTH)) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (beat && in_start),
        .add_i  (row_beat),
        .data_i (in_data),
        .sum_o  (col_sum)
    );

    // Place this beat's row bit into the row vector (cleared at start).
    always_comb begin
        rows_next = in_start ? '0 : rows_q;
        for (int r = 0; r < ROWS; r++) begin
            if (row_beat && (ridx_e == CNTW'(r))) rows_next[r] = row_bit;
        end
    end

    // Final column parity and mismatch words for the closing beat.
    always_comb begin
        col_par_n = col_sum ^ {WIDTH{odd_e}};
        col_err_n = col_sum ^ in_data ^ {WIDTH{odd_e}};
        row_err_n = rows_next;
    end

    par2d_locate #(.ROWS(ROWS), .WIDTH(WIDTH)) u_loc (
        .row_err_i (row_err_n),
        .col_err_i (col_err_n),
        .hit_o     (hit),
        .row_idx_o (hit_row),
        .col_idx_o (hit_col)
    );

    // Track block open state, sampled settings and row position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            mode_q <= MODE_GEN;
            odd_q  <= 1'b0;
            ridx_q <= '0;
            rows_q <= '0;
        end else if (beat) begin
            open_q <= !in_last;
            mode_q <= mode_e;
            odd_q  <= odd_e;
            rows_q <= rows_next;
            if (row_beat && (ridx_e < CNTW'(ROWS))) begin
                ridx_q <= ridx_e + 1'b1;
            end else begin
                ridx_q <= ridx_e;
            end
        end
    end

    // Register the results on the closing beat and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            blk_check_o <= 1'b0;
            col_par_o   <= '0;
            row_par_o   <= '0;
            col_err_o   <= '0;
            row_err_o   <= '0;
            err_loc_o   <= 1'b0;
            loc_row_o   <= '0;
            loc_col_o   <= '0;
        end else begin
            done_o <= beat && in_last;
            if (beat && in_last) begin
                blk_check_o <= (mode_e == MODE_CHK);
                col_par_o   <= col_par_n;
                if (mode_e == MODE_CHK) begin
                    row_par_o <= '0;
                    col_err_o <= col_err_n;
                    row_err_o <= row_err_n;
                    err_loc_o <= hit;
                    loc_row_o <= hit_row;
                    loc_col_o <= hit_col;
                end else begin
                    row_par_o <= rows_next;
                    col_err_o <= '0;
                    row_err_o <= '0;
                    err_loc_o <= 1'b0;
                    loc_row_o <= '0;
                    loc_col_o <= '0;
                end
            end
        end
    end

    // R4
    hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(col_par_o) && $stable(row_err_o) && $stable(col_err_o)));

    // R4
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(in_valid && in_last));

    // R8
    gen_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !blk_check_o) |-> (col_err_o == '0 && row_err_o == '0 && !err_loc_o));

    // R7
    loc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_loc_o |-> ($countones(row_err_o) == 1 && $countones(col_err_o) == 1));

    // R9
    sense_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !(in_valid && in_start)) |=> ($stable(odd_q) && $stable(mode_q)));

    // R10
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ridx_q <= CNTW'(ROWS));

endmodule

// File: tb/sim_par2d_checker.sv
module sim_par2d_checker;
    localparam int ROWS = 4;
    localparam int W    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_start = 0, in_last = 0, in_rpar = 0, odd_sel = 0, check_mode = 0;
    logic [W-1:0] in_data = '0;
    logic done_o, blk_check_o, err_loc_o;
    logic [W-1:0] col_par_o, col_err_o;
    logic [ROWS-1:0] row_par_o, row_err_o;
    logic [1:0] loc_row_o;
    logic [2:0] loc_col_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0] dq [ROWS];
    logic         rq [ROWS];
    logic [W-1:0] pq;

    always #4 clk = ~clk;

    par2d_checker #(.ROWS(ROWS), .WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_data(in_data), .in_rpar(in_rpar),
        .odd_sel(odd_sel), .check_mode(check_mode), .done_o(done_o),
        .blk_check_o(blk_check_o), .col_par_o(col_par_o), .row_par_o(row_par_o),
        .col_err_o(col_err_o), .row_err_o(row_err_o), .err_loc_o(err_loc_o),
        .loc_row_o(loc_row_o), .loc_col_o(loc_col_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference column XOR over the data rows
    function automatic logic [W-1:0] col_xor();
        logic [W-1:0] x = '0;
        for (int r = 0; r < ROWS; r++) x ^= dq[r];
        return x;
    endfunction

    // Make a consistent stored block for the given sense
    task automatic make_clean(input bit odd);
        for (int r = 0; r < ROWS; r++) begin
            dq[r] = W'($urandom);
            rq[r] = (^dq[r]) ^ odd;
        end
        pq = col_xor() ^ {W{odd}};
    endtask

    // Drive one full block; toggle flips the settings after the start beat
    task automatic send(input bit chkm, input bit odd, input bit toggle, input bit gap);
        for (int r = 0; r < ROWS; r++) begin
            if (gap && r == 2) begin
                @(negedge clk);
                in_valid = 0; in_start = 1; in_last = 1; in_data = ~dq[r];
            end
            @(negedge clk);
            in_valid = 1; in_start = (r == 0);
            in_last = !chkm && (r == ROWS - 1);
            in_data = dq[r]; in_rpar = rq[r];
            if (r == 0) begin
                odd_sel = odd; check_mode = chkm;
            end else if (toggle) begin
                odd_sel = ~odd; check_mode = ~chkm;
            end
        end
        if (chkm) begin
            @(negedge clk);
            in_start = 0; in_last = 1; in_data = pq; in_rpar = ~in_rpar;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; in_start = 0; in_last = 0;
    endtask

    // Compare the strobed results with the reference, then check the pulse ends
    task automatic verify(input bit chkm, input bit odd, input string tag);
        logic [W-1:0] x, ecp, ece;
        logic [ROWS-1:0] erp, ere;
        logic eloc;
        logic [1:0] er;
        logic [2:0] ec;
        x = col_xor();
        ecp = x ^ {W{odd}};
        erp = '0; ere = '0; ece = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (chkm) ere[r] = (^dq[r]) ^ rq[r] ^ odd;
            else      erp[r] = (^dq[r]) ^ odd;
        end
        if (chkm) ece = x ^ pq ^ {W{odd}};
        eloc = chkm && ($countones(ere) == 1) && ($countones(ece) == 1);
        er = '0; ec = '0;
        for (int i = 0; i < ROWS; i++) if (eloc && ere[i]) er = 2'(i);
        for (int i = 0; i < W; i++)    if (eloc && ece[i]) ec = 3'(i);
        chk(done_o == 1'b1, {"R4 done ", tag}, 32'(done_o), 1);
        chk(blk_check_o == chkm, {"R9 mode ", tag}, 32'(blk_check_o), 32'(chkm));
        chk(col_par_o == ecp, {"R2 col_par ", tag}, 32'(col_par_o), 32'(ecp));
        chk(row_par_o == erp, {"R3 row_par ", tag}, 32'(row_par_o), 32'(erp));
        chk(col_err_o == ece, {"R5 col_err ", tag}, 32'(col_err_o), 32'(ece));
        chk(row_err_o == ere, {"R5 row_err ", tag}, 32'(row_err_o), 32'(ere));
        chk(err_loc_o == eloc && loc_row_o == er && loc_col_o == ec, {"R7 locate ", tag},
            {err_loc_o, 13'(loc_row_o), 16'(loc_col_o)}, {eloc, 13'(er), 16'(ec)});
        @(negedge clk);
        chk(done_o == 1'b0 && col_par_o == ecp, {"R4 pulse/hold ", tag},
            {31'(col_par_o), done_o}, {31'(ecp), 1'b0});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        bit odd;
        void'($urandom(32'd406));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done_o == 0 && col_par_o == 0 && row_err_o == 0 && err_loc_o == 0,
            "R1 reset", {done_o, err_loc_o, 5'(col_par_o)}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(done_o == 0 && row_par_o == 0 && col_err_o == 0 && blk_check_o == 0,
            "R1 after release", {done_o, 4'(row_par_o)}, 0);

        // R10 stray beats with no start, closing marker included
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1; in_start = 0; in_last = (i == 2); in_data = W'($urandom);
        end
        @(negedge clk); in_valid = 0; in_last = 0;
        @(negedge clk);
        chk(done_o == 0 && col_par_o == 0, "R10 stray beats", {done_o, 5'(col_par_o)}, 0);

        // R2 R3 random generate blocks, with idle gaps (R10)
        for (int k = 0; k < 16; k++) begin
            odd = 1'($urandom);
            for (int r = 0; r < ROWS; r++) begin dq[r] = W'($urandom); rq[r] = 1'($urandom); end
            send(0, odd, 0, k[0]);
            verify(0, odd, "gen random");
        end
        // R2 corner: all ones, both senses
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < ROWS; r++) begin dq[r] = '1; rq[r] = 0; end
            send(0, 1'(s), 0, 0);
            verify(0, 1'(s), "gen all ones");
        end

        // R5 R8 clean check blocks
        for (int k = 0; k < 6; k++) begin
            odd = 1'($urandom);
            make_clean(odd);
            send(1, odd, 0, k[0]);
            verify(1, odd, "check clean");
        end
        // R7 single data bit flips
        for (int k = 0; k < 8; k++) begin
            int rr, cc;
            odd = 1'($urandom);
            make_clean(odd);
            rr = $urandom_range(ROWS - 1); cc = $urandom_range(W - 1);
            dq[rr][cc] = ~dq[rr][cc];
            send(1, odd, 0, 0);
            verify(1, odd, "check single flip");
        end
        // R6 adjacent burst in one row
        for (int k = 0; k < 6; k++) begin
            int rr, cc;
            odd = 1'($urandom);
            make_clean(odd);
            rr = $urandom_range(ROWS - 1); cc = $urandom_range(W - 2);
            dq[rr][cc] = ~dq[rr][cc]; dq[rr][cc+1] = ~dq[rr][cc+1];
            send(1, odd, 0, 0);
            chk(1, "R6 burst sent", 0, 0);
            verify(1, odd, "R6 burst");
        end
        // R5 flipped stored column parity bit, no location
        make_clean(1);
        pq[2] = ~pq[2];
        send(1, 1, 0, 0);
        verify(1, 1, "stored parity flip");
        // R5 random multi-bit damage
        for (int k = 0; k < 6; k++) begin
            odd = 1'($urandom);
            make_clean(odd);
            dq[$urandom_range(ROWS - 1)] ^= W'($urandom);
            rq[$urandom_range(ROWS - 1)] ^= 1'($urandom);
            send(1, odd, 0, 0);
            verify(1, odd, "check random damage");
        end

        // R9 settings toggled after the start beat, both modes
        make_clean(0);
        send(0, 0, 1, 0);
        verify(0, 0, "R9 gen toggle");
        make_clean(1);
        dq[1][0] = ~dq[1][0];
        send(1, 1, 1, 0);
        verify(1, 1, "R9 check toggle");

        // R11 restart: two rows of a block, then a full new block
        for (int r = 0; r < 2; r++) begin
            @(negedge clk);
            in_valid = 1; in_start = (r == 0); in_last = 0; in_data = '1; odd_sel = 1; check_mode = 0;
        end
        for (int r = 0; r < ROWS; r++) dq[r] = W'($urandom);
        send(0, 0, 0, 0);
        verify(0, 0, "R11 restart");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule